// File: doc/BRIEF.md
# Shared-Line PCI Interrupt Router

This block sits between the interrupt pins of the PCI slots on a board and a legacy 16-line interrupt controller. Each slot has four pins; each pin is mapped through a per-slot table onto one of four routing links, and each link carries a programmable IRQ number. Two on-board interrupt sources bypass the slot tables and carry their own IRQ numbers and enable bits. Requests reach the block as one-cycle set and clear strobes per slot pin and per on-board source. The router answers with one-cycle raise and clear pulses toward the interrupt controller, each a 16-bit one-hot line vector.

Every IRQ line is either edge or level mode, chosen by two 8-bit trigger-mode registers at two adjacent I/O addresses, low lines at the base address and high lines at base+1. On edge lines every accepted set raises the line and every accepted clear drops it. On level lines the router keeps a 32-bit holder mask per line, so several sources can share a line like a wired-OR: the line is raised only when the first holder arrives and dropped only when the last holder leaves. Slot n owns holder bit n; the two on-board sources own bits 30 and 31.

Requests that arrive together are latched as pending and served one per cycle in fixed priority order. A soft reset input drops every held line at once and returns both trigger-mode registers to edge mode.

Top module: `irq_share_router`

## Requirements
- R1: A write to the trigger-mode register at ELCR_BASE (lines 0..7) stores the data ANDed with 8'hF8; a write at ELCR_BASE+1 (lines 8..15) stores the data ANDed with 8'hDE, so lines 0, 1, 2, 8 and 13 stay in edge mode. io_rdata returns the stored value at those two addresses and 8'hFF at any other address.
- R2: Line n is level mode when bit n of the 16-bit value {high register, low register} is set; for n above 7 this is bit n-8 of the high register.
- R3: Link and on-board IRQ settings (cfg_kind 0 = link IRQ, index 0..3; cfg_kind 1 = on-board IRQ, index 0..1) take a byte whose value above 15 means disabled; all links and sources are disabled and all on-board enables are 0 after rst_n. Events that resolve to a disabled link or source produce no pulse and change no holder mask.
- R4: Pin map writes use cfg_kind 3 with index slot*4+pin (pin 0..3 = A..D). A stored byte of 0 leaves the pin unrouted (its events are ignored); a nonzero byte e selects link (e-1) mod 4.
- R5: On an edge-mode line, every accepted set produces a raise pulse and every accepted clear produces a clear pulse, regardless of earlier events.
- R6: On a level-mode line, a set from a source that already holds the line has no effect; otherwise the source becomes a holder, and a raise pulse is produced only if the line had no holder before.
- R7: On a level-mode line, a clear from a non-holder has no effect; a clear from a holder removes it, and a clear pulse is produced only when no holder remains.
- R8: On-board sources 0 and 1 use holder bits 30 and 31 and share lines with slots under R6 and R7; they act only while their enable (cfg_kind 2, index 0..1, data bit 0) is 1.
- R9: A soft_rst pulse produces, in the next cycle, one clear pulse whose vector has a bit set for every line that had a holder, empties all holder masks and writes both trigger-mode registers to zero.
- R10: Raise and clear outputs are high for one cycle only; a raise vector has at most one bit set. A request strobed on clock edge k produces its pulse in the cycle after edge k+1.
- R11: Requests that arrive together are served one per cycle, lowest source index first (slot pin slot*4+pin, then on-board 0, then on-board 1). A set and a clear strobed together for one source act as the clear alone.
- R12: After rst_n both trigger-mode registers read 0 and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all state |
| soft_rst | input | 1 | Router reset strobe: release all lines, zero trigger modes |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address for write and read-back |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read-back of the trigger-mode register at io_addr |
| cfg_we | input | 1 | Routing configuration write strobe |
| cfg_kind | input | 2 | Configuration target: 0 link IRQ, 1 on-board IRQ, 2 on-board enable, 3 pin map |
| cfg_index | input | 8 | Link, source or slot*4+pin index |
| cfg_value | input | 8 | Configuration byte |
| slot_set | input | NUM_SLOTS*4 | Set strobes, bit slot*4+pin |
| slot_clr | input | NUM_SLOTS*4 | Clear strobes, bit slot*4+pin |
| brd_set | input | 2 | Set strobes of the on-board sources |
| brd_clr | input | 2 | Clear strobes of the on-board sources |
| irq_raise | output | 16 | One-cycle raise pulse, one-hot by line |
| irq_clear | output | 16 | One-cycle clear pulse, by line |

## Verification
The properties assume that trigger modes change only while no holder is affected by the change, that slot counts stay below 31 so slot holder bits never meet the on-board bits, and that strobes are single-cycle pulses. The stimulus programs the trigger-mode registers and the routing once before any event, changes them again only after a soft reset has emptied every holder mask, and drives every strobe for exactly one clock. Priority and latency are checked cycle by cycle; all other table steps leave several idle cycles between events so that each pulse is attributed to one request.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;

  localparam int NUM_IRQ   = 16;
  localparam int HOLD_W    = 32;
  localparam int NUM_LINKS = 4;
  localparam int NUM_BRD   = 2;
  localparam int PIN_CODE0 = 1;  // map byte that selects link 0

  typedef enum logic [1:0] {
    CFG_LINK_IRQ = 2'd0,
    CFG_BRD_IRQ  = 2'd1,
    CFG_BRD_EN   = 2'd2,
    CFG_PIN_MAP  = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    logic       off;
    logic [3:0] irq;
  } irq_sel_t;

  typedef struct packed {
    logic       routed;
    logic [1:0] link;
  } pin_map_t;

  function automatic logic [7:0] mask_mode_lo(input logic [7:0] v);
    return v & 8'hF8;
  endfunction

  function automatic logic [7:0] mask_mode_hi(input logic [7:0] v);
    return v & 8'hDE;
  endfunction

  function automatic irq_sel_t decode_irq(input logic [7:0] v);
    irq_sel_t s;
    s.off = (v > 8'd15);
    s.irq = v[3:0];
    return s;
  endfunction

  function automatic pin_map_t decode_pin(input logic [7:0] v);
    pin_map_t p;
    logic [7:0] d;
    d        = v - 8'(PIN_CODE0);
    p.routed = (v != 8'd0);
    p.link   = d[1:0];
    return p;
  endfunction

  function automatic logic [NUM_IRQ-1:0] line_vec(input logic [3:0] n);
    return NUM_IRQ'(1) << n;
  endfunction

endpackage

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
  import irq_rtr_pkg::*;
#(
  parameter logic [15:0] BASE = 16'h04D0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [15:0] level_map
);
  localparam logic [15:0] ADDR_HI = BASE + 16'd1;

  logic [7:0] mode_lo_q, mode_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo_q <= 8'h00;
      mode_hi_q <= 8'h00;
    end else if (soft_rst) begin
      mode_lo_q <= 8'h00;
      mode_hi_q <= 8'h00;
    end else if (io_wr) begin
      if (io_addr == BASE)    mode_lo_q <= mask_mode_lo(io_wdata);
      if (io_addr == ADDR_HI) mode_hi_q <= mask_mode_hi(io_wdata);
    end
  end

  always_comb begin
    if (io_addr == BASE)         io_rdata = mode_lo_q;
    else if (io_addr == ADDR_HI) io_rdata = mode_hi_q;
    else                         io_rdata = 8'hFF;
  end

  assign level_map = {mode_hi_q, mode_lo_q};

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_rtr_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  cfg_kind_e                       cfg_kind,
  input  logic [7:0]                      cfg_index,
  input  logic [7:0]                      cfg_value,
  output irq_sel_t [NUM_LINKS-1:0]        link_sel,
  output irq_sel_t [NUM_BRD-1:0]          brd_sel,
  output logic [NUM_BRD-1:0]              brd_en,
  output pin_map_t [NUM_SLOTS*4-1:0]      pin_map
);
  localparam int NPINS = NUM_SLOTS * 4;
  localparam irq_sel_t SEL_OFF = '{off: 1'b1, irq: 4'hF};

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) link_sel[l] <= SEL_OFF;
      else if (cfg_we && cfg_kind == CFG_LINK_IRQ && cfg_index == 8'(l))
        link_sel[l] <= decode_irq(cfg_value);
    end
  end

  for (genvar b = 0; b < NUM_BRD; b++) begin : g_brd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        brd_sel[b] <= SEL_OFF;
        brd_en[b]  <= 1'b0;
      end else if (cfg_we && cfg_index == 8'(b)) begin
        if (cfg_kind == CFG_BRD_IRQ) brd_sel[b] <= decode_irq(cfg_value);
        if (cfg_kind == CFG_BRD_EN)  brd_en[b]  <= cfg_value[0];
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_map[p] <= '0;
      else if (cfg_we && cfg_kind == CFG_PIN_MAP && cfg_index == 8'(p))
        pin_map[p] <= decode_pin(cfg_value);
    end
  end

endmodule

// File: rtl/irq_event_queue.sv
module irq_event_queue #(
  parameter int NSRC  = 34,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic [NSRC-1:0]  req_set,
  input  logic [NSRC-1:0]  req_clr,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_clear
);
  logic [NSRC-1:0] set_p, clr_p, busy;

  assign busy = set_p | clr_p;

  // lowest pending index wins
  always_comb begin
    gnt_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (busy[i]) gnt_idx = IDX_W'(i);
  end

  assign gnt_valid = (|busy) && !stall;
  assign gnt_clear = clr_p[gnt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_p <= '0;
      clr_p <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (req_clr[i]) begin
          clr_p[i] <= 1'b1;
          set_p[i] <= 1'b0;
        end else if (req_set[i]) begin
          set_p[i] <= 1'b1;
          clr_p[i] <= 1'b0;
        end else if (gnt_valid && gnt_idx == IDX_W'(i)) begin
          set_p[i] <= 1'b0;
          clr_p[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_hold_engine.sv
module irq_hold_engine
  import irq_rtr_pkg::*;
#(
  localparam int BIT_W = $clog2(HOLD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               ev_valid,
  input  logic               ev_clear,
  input  logic               ev_off,
  input  logic [3:0]         ev_irq,
  input  logic [BIT_W-1:0]   ev_bit,
  input  logic [NUM_IRQ-1:0] level_map,
  output logic [NUM_IRQ-1:0] irq_raise,
  output logic [NUM_IRQ-1:0] irq_clear,
  output logic [NUM_IRQ-1:0] line_held
);
  logic [HOLD_W-1:0] hold_q [NUM_IRQ];
  logic              lvl, mine, others, live;
  logic              do_raise, do_clear, take_bit, drop_bit;
  logic [HOLD_W-1:0] own_bit;

  for (genvar l = 0; l < NUM_IRQ; l++) begin : g_held
    assign line_held[l] = |hold_q[l];
  end

  always_comb begin
    own_bit  = HOLD_W'(1) << ev_bit;
    lvl      = level_map[ev_irq];
    mine     = |(hold_q[ev_irq] & own_bit);
    others   = |(hold_q[ev_irq] & ~own_bit);
    live     = ev_valid && !ev_off;
    do_raise = live && !ev_clear && (!lvl || !line_held[ev_irq]);
    take_bit = live && !ev_clear && lvl;
    drop_bit = live && ev_clear && lvl && mine;
    do_clear = live && ev_clear && (!lvl || (mine && !others));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_IRQ; l++) hold_q[l] <= '0;
      irq_raise <= '0;
      irq_clear <= '0;
    end else if (soft_rst) begin
      for (int l = 0; l < NUM_IRQ; l++) hold_q[l] <= '0;
      irq_raise <= '0;
      irq_clear <= line_held;
    end else begin
      irq_raise <= do_raise ? line_vec(ev_irq) : '0;
      irq_clear <= do_clear ? line_vec(ev_irq) : '0;
      if (take_bit) hold_q[ev_irq] <= hold_q[ev_irq] | own_bit;
      if (drop_bit) hold_q[ev_irq] <= hold_q[ev_irq] & ~own_bit;
    end
  end

endmodule

// File: rtl/irq_share_router.sv
module irq_share_router
  import irq_rtr_pkg::*;
#(
  parameter int          NUM_SLOTS = 8,
  parameter logic [15:0] ELCR_BASE = 16'h04D0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   io_wr,
  input  logic [15:0]            io_addr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_kind,
  input  logic [7:0]             cfg_index,
  input  logic [7:0]             cfg_value,
  input  logic [NUM_SLOTS*4-1:0] slot_set,
  input  logic [NUM_SLOTS*4-1:0] slot_clr,
  input  logic [1:0]             brd_set,
  input  logic [1:0]             brd_clr,
  output logic [15:0]            irq_raise,
  output logic [15:0]            irq_clear
);
  localparam int NPINS = NUM_SLOTS * 4;
  localparam int NSRC  = NPINS + NUM_BRD;
  localparam int IDX_W = $clog2(NSRC);
  localparam int PIN_W = $clog2(NPINS);
  localparam int BIT_W = $clog2(HOLD_W);

  irq_sel_t [NUM_LINKS-1:0] link_sel;
  irq_sel_t [NUM_BRD-1:0]   brd_sel;
  logic [NUM_BRD-1:0]       brd_en;
  pin_map_t [NPINS-1:0]     pin_map;
  logic [NUM_IRQ-1:0]       level_map;
  logic [NUM_IRQ-1:0]       line_held;

  logic             gnt_valid, gnt_clear;
  logic [IDX_W-1:0] gnt_idx;
  logic             ev_off;
  logic [3:0]       ev_irq;
  logic [BIT_W-1:0] ev_bit;
  pin_map_t         pm;
  irq_sel_t         sel;

  irq_mode_regs #(.BASE(ELCR_BASE)) u_mode (
    .clk, .rst_n, .soft_rst, .io_wr, .io_addr, .io_wdata, .io_rdata, .level_map
  );

  irq_route_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk, .rst_n, .cfg_we,
    .cfg_kind (cfg_kind_e'(cfg_kind)),
    .cfg_index, .cfg_value, .link_sel, .brd_sel, .brd_en, .pin_map
  );

  irq_event_queue #(.NSRC(NSRC)) u_queue (
    .clk, .rst_n,
    .stall     (soft_rst),
    .req_set   ({brd_set, slot_set}),
    .req_clr   ({brd_clr, slot_clr}),
    .gnt_valid, .gnt_idx, .gnt_clear
  );

  // resolve the granted source to a line, a holder bit and an enable
  always_comb begin
    pm = pin_map[gnt_idx[PIN_W-1:0]];
    if (gnt_idx < IDX_W'(NPINS)) begin
      sel    = link_sel[pm.link];
      ev_off = !pm.routed || sel.off;
      ev_bit = BIT_W'(gnt_idx >> 2);
    end else begin
      // NPINS is a multiple of four, so bit 0 names the on-board source
      sel    = brd_sel[gnt_idx[0]];
      ev_off = !brd_en[gnt_idx[0]] || sel.off;
      ev_bit = BIT_W'(HOLD_W - 2 + int'(gnt_idx[0]));
    end
    ev_irq = sel.irq;
  end

  irq_hold_engine u_engine (
    .clk, .rst_n, .soft_rst,
    .ev_valid (gnt_valid),
    .ev_clear (gnt_clear),
    .ev_off, .ev_irq, .ev_bit, .level_map,
    .irq_raise, .irq_clear, .line_held
  );

endmodule

// File: rtl/irq_share_router_chk.sv
module irq_share_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic [15:0] irq_raise,
  input logic [15:0] irq_clear,
  input logic [15:0] line_held,
  input logic [15:0] level_map,
  input logic        gnt_valid,
  input logic        gnt_clear,
  input logic        ev_off,
  input logic [3:0]  ev_irq
);

  p_raise_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_raise));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise & irq_clear) == 16'h0);

  p_mode_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level_map & 16'h2107) == 16'h0);

  p_held_no_reraise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_clear && !ev_off && level_map[ev_irq] && line_held[ev_irq])
      |=> irq_raise == 16'h0);

  p_last_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear & $past(level_map) & line_held) == 16'h0);

  p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && ev_off) |=> (irq_raise | irq_clear) == 16'h0);

  p_soft_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> line_held == 16'h0);

endmodule

bind irq_share_router irq_share_router_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .irq_raise (irq_raise),
  .irq_clear (irq_clear),
  .line_held (line_held),
  .level_map (level_map),
  .gnt_valid (gnt_valid),
  .gnt_clear (gnt_clear),
  .ev_off    (ev_off),
  .ev_irq    (ev_irq)
);

// File: tb/irq_share_router_bench.sv
module irq_share_router_bench;

  localparam int NS = 8;
  localparam int NV = 17;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, soft_rst = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0, io_rdata;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = 2'd0;
  logic [7:0]  cfg_index = 8'h0, cfg_value = 8'h0;
  logic [NS*4-1:0] slot_set = '0, slot_clr = '0;
  logic [1:0]  brd_set = 2'b0, brd_clr = 2'b0;
  logic [15:0] irq_raise, irq_clear;

  irq_share_router #(.NUM_SLOTS(NS)) u_irq_share_router (
    .clk, .rst_n, .soft_rst, .io_wr, .io_addr, .io_wdata, .io_rdata,
    .cfg_we, .cfg_kind, .cfg_index, .cfg_value,
    .slot_set, .slot_clr, .brd_set, .brd_clr, .irq_raise, .irq_clear
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] acc_r = 16'h0, acc_c = 16'h0;

  always @(negedge clk) begin
    acc_r = acc_r | irq_raise;
    acc_c = acc_c | irq_clear;
  end

  // {on-board, source, clear, expected raise, expected clear}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 7'd0,  1'b0, 16'h0400, 16'h0000},  // R6 first holder raises IRQ10
    {1'b0, 7'd0,  1'b0, 16'h0000, 16'h0000},  // R6 repeat set from holder
    {1'b0, 7'd9,  1'b0, 16'h0000, 16'h0000},  // R2 R4 R6 map byte 5 -> link 0, shared
    {1'b0, 7'd0,  1'b1, 16'h0000, 16'h0000},  // R7 one holder remains
    {1'b0, 7'd0,  1'b1, 16'h0000, 16'h0000},  // R7 clear from non-holder
    {1'b0, 7'd9,  1'b1, 16'h0000, 16'h0400},  // R7 last holder drops line
    {1'b0, 7'd4,  1'b0, 16'h2000, 16'h0000},  // R5 edge raise IRQ13
    {1'b0, 7'd4,  1'b0, 16'h2000, 16'h0000},  // R5 edge raise again
    {1'b0, 7'd4,  1'b1, 16'h0000, 16'h2000},  // R5 edge clear
    {1'b0, 7'd4,  1'b1, 16'h0000, 16'h2000},  // R5 edge clear again
    {1'b0, 7'd14, 1'b0, 16'h0000, 16'h0000},  // R3 link 3 disabled
    {1'b0, 7'd19, 1'b0, 16'h0000, 16'h0000},  // R4 unrouted pin
    {1'b1, 7'd0,  1'b0, 16'h0400, 16'h0000},  // R8 on-board 0 raises IRQ10
    {1'b0, 7'd0,  1'b0, 16'h0000, 16'h0000},  // R8 slot joins on-board holder
    {1'b1, 7'd0,  1'b1, 16'h0000, 16'h0000},  // R8 slot still holds
    {1'b0, 7'd0,  1'b1, 16'h0000, 16'h0400},  // R8 last holder drops
    {1'b0, 7'd12, 1'b0, 16'h0800, 16'h0000}   // R2 IRQ11 level raise
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_w(input int kind, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_index = 8'(idx); cfg_value = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic io_w(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_r(input logic [15:0] a, output logic [7:0] d);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic ev(input logic brd, input int src, input logic clr);
    @(negedge clk);
    acc_r = 16'h0; acc_c = 16'h0;
    if (brd) begin
      if (clr) brd_clr[src] = 1'b1; else brd_set[src] = 1'b1;
    end else begin
      if (clr) slot_clr[src] = 1'b1; else slot_set[src] = 1'b1;
    end
    @(negedge clk);
    brd_set = '0; brd_clr = '0; slot_set = '0; slot_clr = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    io_r(16'h04D0, rd); chk("R12 low mode after reset", 16'(rd), 16'h0000);
    io_r(16'h04D1, rd); chk("R12 high mode after reset", 16'(rd), 16'h0000);
    chk("R12 no raise after reset", irq_raise, 16'h0000);
    ev(1'b1, 0, 1'b0);
    chk("R3 R8 on-board source disabled after reset", acc_r | acc_c, 16'h0000);

    // R1 masking and read-back
    io_w(16'h04D0, 8'hFF);
    io_w(16'h04D1, 8'hFF);
    io_r(16'h04D0, rd); chk("R1 low mask", 16'(rd), 16'h00F8);
    io_r(16'h04D1, rd); chk("R1 high mask", 16'(rd), 16'h00DE);
    io_r(16'h04D2, rd); chk("R1 other address", 16'(rd), 16'h00FF);

    // routing setup
    cfg_w(0, 0, 10); cfg_w(0, 1, 13); cfg_w(0, 2, 11); cfg_w(0, 3, 8'hFF);
    cfg_w(1, 0, 10); cfg_w(1, 1, 16); cfg_w(2, 0, 1); cfg_w(2, 1, 1);
    cfg_w(3, 0, 1); cfg_w(3, 4, 2); cfg_w(3, 9, 5); cfg_w(3, 12, 3);
    cfg_w(3, 14, 4); cfg_w(3, 19, 0);

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      string tag;
      v = VEC[i];
      ev(v[40], int'(v[39:33]), v[32]);
      tag = $sformatf("table step %0d raise (R4 R5 R6 R7 R8)", i);
      chk(tag, acc_r, v[31:16]);
      tag = $sformatf("table step %0d clear (R4 R5 R6 R7 R8)", i);
      chk(tag, acc_c, v[15:0]);
    end

    // R3 on-board source with IRQ value 16
    ev(1'b1, 1, 1'b0);
    chk("R3 value above 15 disables", acc_r | acc_c, 16'h0000);

    // R9 soft reset with IRQ11 held
    @(negedge clk);
    acc_r = 16'h0; acc_c = 16'h0;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 soft reset clear pulse", acc_c, 16'h0800);
    io_r(16'h04D0, rd); chk("R9 low mode zeroed", 16'(rd), 16'h0000);
    io_r(16'h04D1, rd); chk("R9 high mode zeroed", 16'(rd), 16'h0000);

    // R2 IRQ11 now edge: each set raises
    ev(1'b0, 12, 1'b0); chk("R2 R5 edge after soft reset", acc_r, 16'h0800);
    ev(1'b0, 12, 1'b0); chk("R2 R5 edge raise again", acc_r, 16'h0800);

    // R8 enable off
    cfg_w(2, 0, 0);
    ev(1'b1, 0, 1'b0);
    chk("R8 disabled on-board source", acc_r | acc_c, 16'h0000);

    // R10 R11 latency and priority: slot 3 pin A (12) and slot 1 pin A (4)
    @(negedge clk);
    slot_set[12] = 1'b1; slot_set[4] = 1'b1;
    @(negedge clk);
    slot_set = '0;
    chk("R10 nothing after first edge", irq_raise, 16'h0000);
    @(negedge clk);
    chk("R10 R11 lower index first", irq_raise, 16'h2000);
    @(negedge clk);
    chk("R11 higher index next", irq_raise, 16'h0800);
    @(negedge clk);
    chk("R10 pulse lasts one cycle", irq_raise, 16'h0000);

    // R11 set and clear together
    @(negedge clk);
    acc_r = 16'h0; acc_c = 16'h0;
    slot_set[4] = 1'b1; slot_clr[4] = 1'b1;
    @(negedge clk);
    slot_set = '0; slot_clr = '0;
    repeat (4) @(negedge clk);
    chk("R11 clear wins raise", acc_r, 16'h0000);
    chk("R11 clear wins clear", acc_c, 16'h2000);

    summary();
    $finish;
  end

endmodule